// File: doc/BRIEF.md
# Memory-Mapped 64-bit Global Timer

This block is a wide free-running time base for a processor cluster. It holds a 64-bit up-counter that software reaches through a small 32-bit register bus, one word per access. A programmable prescaler sets how many clock cycles pass per count. The counter can be stopped, loaded half by half and started again.

A 64-bit comparator watches the counter. When comparison is enabled and the counter has reached the comparator value, a sticky event flag is raised. When interrupts are enabled, the flag drives a registered interrupt line. In periodic mode the comparator moves forward by a programmable 32-bit step on every event, so events repeat at a fixed spacing. In one-shot mode the comparator stays put and the event fires once per comparator write.

The bus addresses words: `bus_addr` is the word index, so byte offset = 4 × index. A read returns data one cycle after its strobe.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register, the read data output and the interrupt output are zero.
- R2: Word index map: 0 counter bits 31:0, 1 counter bits 63:32, 2 control, 3 status, 4 comparator bits 31:0, 5 comparator bits 63:32, 6 step. Control fields: bits 15:8 prescale, bit 3 periodic mode (1) / one-shot (0), bit 2 interrupt enable, bit 1 compare enable, bit 0 run. Status bit 0 is the event flag. Unused control and status bits read zero and ignore writes. Index 7 reads zero.
- R3: While run is set, the counter advances by one every (prescale + 1) cycles. The first advance comes prescale + 1 cycles after the edge that sets run, because the prescaler restarts each time run is set.
- R4: While run is clear, the counter holds its value. A write to either counter half loads that half and takes priority over a count.
- R5: A count carries from bit 31 into bit 32 on the same clock edge.
- R6: A comparator write arms the comparator. While armed, with compare enabled, a counter value greater than or equal to the comparator value causes an event. The event sets the flag on the next edge.
- R7: The event flag stays set until software writes 1 to status bit 0. If an event and a clear happen in the same cycle, the event wins.
- R8: In periodic mode each event adds the step (zero-extended) to the 64-bit comparator on the same edge that sets the flag. A comparator write in the same cycle takes priority over the add.
- R9: In one-shot mode an event leaves the comparator unchanged and disarms it. No further event occurs until the comparator is written again.
- R10: The interrupt output is a register loaded with (event flag AND interrupt enable). It follows the flag one cycle later.
- R11: A read strobe loads the read data register on its edge. The register holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word index of the access |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Read data is due one edge after the read strobe. The bench samples it at the falling edge that follows. A counter sampled by a read at edge R holds the counts made at edges up to R-1. With run set at edge E and prescale p, that is floor((R-1-E)/(p+1)) counts past the loaded value, and the bench computes this from its own edge counter. The event flag is due on the edge after the counter reaches the comparator, and the interrupt one edge after that. The bench waits for those exact edge numbers and checks the interrupt on both sides of its rise, so a result that comes one cycle early or late is caught.

// File: rtl/gtmr_pkg.sv
// Package: shared register selects and decode for the global timer.
// Assumes word-indexed addressing with a 3-bit index.
package gtmr_pkg;

    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_CMP_LO = 3'd4,
        SEL_CMP_HI = 3'd5,
        SEL_STEP   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // Map a word index to a register select.
    function automatic reg_sel_e decode_sel(input logic [2:0] idx);
        case (idx)
            3'd0:    return SEL_CNT_LO;
            3'd1:    return SEL_CNT_HI;
            3'd2:    return SEL_CTRL;
            3'd3:    return SEL_STAT;
            3'd4:    return SEL_CMP_LO;
            3'd5:    return SEL_CMP_HI;
            3'd6:    return SEL_STEP;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gtmr_ctrl.sv
// Control register: prescale, periodic mode, interrupt enable,
// compare enable and run. Assumes the caller qualifies the write
// strobe with the address decode. Unused bits are not stored.
module gtmr_ctrl #(
    parameter int BUS_W   = 32,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [PRESC_W-1:0] wr_presc,
    input  logic [3:0]         wr_flags,
    output logic [PRESC_W-1:0] presc,
    output logic               auto_inc,
    output logic               irq_en,
    output logic               cmp_en,
    output logic               run,
    output logic [BUS_W-1:0]   rd_word
);
    localparam int PAD_W = BUS_W - PRESC_W - 8;

    // Store the writable fields of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc    <= '0;
            auto_inc <= 1'b0;
            irq_en   <= 1'b0;
            cmp_en   <= 1'b0;
            run      <= 1'b0;
        end else if (wr) begin
            presc    <= wr_presc;
            auto_inc <= wr_flags[3];
            irq_en   <= wr_flags[2];
            cmp_en   <= wr_flags[1];
            run      <= wr_flags[0];
        end
    end

    // Rebuild the control word for reads, unused bits as zero.
    always_comb begin
        rd_word = {{PAD_W{1'b0}}, presc, 4'b0000, auto_inc, irq_en, cmp_en, run};
    end

endmodule

// File: rtl/gtmr_prescaler.sv
// Prescaler: produces one tick every (presc + 1) cycles while run is set.
// Held at zero while stopped, so it restarts whenever run rises.
// A ">=" test keeps it safe when presc is lowered mid-count.
module gtmr_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] pcnt;

    // Tick when the divider has reached the prescale value.
    always_comb begin
        tick = run && (pcnt >= presc);
    end

    // Advance the divider, clearing it on a tick or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/gtmr_counter.sv
// Wide up-counter built from NHALF bus-width words. A write to a word
// replaces that word and wins over a count. The count is one full-width
// add, so a carry crosses words on the same edge.
module gtmr_counter #(
    parameter int HALF_W = 32,
    parameter int NHALF  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NHALF-1:0]         wr_half,
    input  logic [HALF_W-1:0]        wdata,
    output logic [NHALF*HALF_W-1:0]  cnt
);
    localparam int CNT_W = NHALF * HALF_W;

    logic [CNT_W-1:0] cnt_next;

    // Full-width increment on a tick.
    always_comb begin
        cnt_next = tick ? cnt + {{(CNT_W-1){1'b0}}, 1'b1} : cnt;
    end

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        // Load one word from the bus or take the incremented value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[g*HALF_W +: HALF_W] <= '0;
            end else if (wr_half[g]) begin
                cnt[g*HALF_W +: HALF_W] <= wdata;
            end else begin
                cnt[g*HALF_W +: HALF_W] <= cnt_next[g*HALF_W +: HALF_W];
            end
        end
    end

endmodule

// File: rtl/gtmr_comparator.sv
// Comparator, step register, event flag and interrupt register.
// An event needs compare enable, an armed comparator and cnt >= cmp.
// A comparator write arms it. A one-shot event disarms it. A periodic
// event adds the step. Assumes write strobes are already decoded.
module gtmr_comparator #(
    parameter int HALF_W = 32,
    parameter int NHALF  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NHALF*HALF_W-1:0]  cnt,
    input  logic                     cmp_en,
    input  logic                     auto_inc,
    input  logic                     irq_en,
    input  logic [NHALF-1:0]         wr_cmp,
    input  logic                     wr_step,
    input  logic                     clr_flag,
    input  logic [HALF_W-1:0]        wdata,
    output logic [NHALF*HALF_W-1:0]  cmp,
    output logic [HALF_W-1:0]        step,
    output logic                     flag,
    output logic                     fire,
    output logic                     irq_q
);
    localparam int CMP_W = NHALF * HALF_W;

    logic             armed;
    logic             add_ok;
    logic [CMP_W-1:0] cmp_sum;

    // Detect an event and decide whether the comparator advances.
    always_comb begin
        fire    = cmp_en && armed && (cnt >= cmp);
        add_ok  = fire && auto_inc && !(|wr_cmp);
        cmp_sum = cmp + {{(CMP_W-HALF_W){1'b0}}, step};
    end

    for (genvar g = 0; g < NHALF; g++) begin : g_cmp
        // Load a comparator word from the bus or advance it by the step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp[g*HALF_W +: HALF_W] <= '0;
            end else if (wr_cmp[g]) begin
                cmp[g*HALF_W +: HALF_W] <= wdata;
            end else if (add_ok) begin
                cmp[g*HALF_W +: HALF_W] <= cmp_sum[g*HALF_W +: HALF_W];
            end
        end
    end

    // Hold the step value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (wr_step) begin
            step <= wdata;
        end
    end

    // Arm on a comparator write, disarm after a one-shot event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (|wr_cmp) begin
            armed <= 1'b1;
        end else if (fire && !auto_inc) begin
            armed <= 1'b0;
        end
    end

    // Sticky flag: an event sets it, a clear resets it, the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (clr_flag) begin
            flag <= 1'b0;
        end
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= flag && irq_en;
        end
    end

endmodule

// File: rtl/gtmr_top.sv
// Global timer top: word-indexed register decode, read mux, and the
// prescaler, counter, control and comparator units. Assumes single-cycle
// read and write strobes that never overlap.
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int PRESC_W = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_rd,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_o
);
    localparam int NHALF = 2;
    localparam int CNT_W = NHALF * BUS_W;

    reg_sel_e           sel;
    logic               wr_ctrl;
    logic               wr_step;
    logic               clr_flag;
    logic [NHALF-1:0]   wr_cnt;
    logic [NHALF-1:0]   wr_cmp;
    logic [PRESC_W-1:0] presc;
    logic               auto_inc;
    logic               irq_en;
    logic               cmp_en;
    logic               run;
    logic [BUS_W-1:0]   ctrl_word;
    logic               tick;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp;
    logic [BUS_W-1:0]   step;
    logic               flag;
    logic               fire;
    logic [BUS_W-1:0]   rd_mux;

    // Decode the word index into per-register write strobes.
    always_comb begin
        sel       = decode_sel(bus_addr);
        wr_ctrl   = bus_wr && (sel == SEL_CTRL);
        wr_step   = bus_wr && (sel == SEL_STEP);
        clr_flag  = bus_wr && (sel == SEL_STAT) && bus_wdata[0];
        wr_cnt[0] = bus_wr && (sel == SEL_CNT_LO);
        wr_cnt[1] = bus_wr && (sel == SEL_CNT_HI);
        wr_cmp[0] = bus_wr && (sel == SEL_CMP_LO);
        wr_cmp[1] = bus_wr && (sel == SEL_CMP_HI);
    end

    gtmr_ctrl #(
        .BUS_W   (BUS_W),
        .PRESC_W (PRESC_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ctrl),
        .wr_presc (bus_wdata[8 +: PRESC_W]),
        .wr_flags (bus_wdata[3:0]),
        .presc    (presc),
        .auto_inc (auto_inc),
        .irq_en   (irq_en),
        .cmp_en   (cmp_en),
        .run      (run),
        .rd_word  (ctrl_word)
    );

    gtmr_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .presc (presc),
        .tick  (tick)
    );

    gtmr_counter #(
        .HALF_W (BUS_W),
        .NHALF  (NHALF)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_half (wr_cnt),
        .wdata   (bus_wdata),
        .cnt     (cnt)
    );

    gtmr_comparator #(
        .HALF_W (BUS_W),
        .NHALF  (NHALF)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp_en   (cmp_en),
        .auto_inc (auto_inc),
        .irq_en   (irq_en),
        .wr_cmp   (wr_cmp),
        .wr_step  (wr_step),
        .clr_flag (clr_flag),
        .wdata    (bus_wdata),
        .cmp      (cmp),
        .step     (step),
        .flag     (flag),
        .fire     (fire),
        .irq_q    (irq_o)
    );

    // Select the addressed word; unmapped indices give zero.
    always_comb begin
        case (sel)
            SEL_CNT_LO: rd_mux = cnt[BUS_W-1:0];
            SEL_CNT_HI: rd_mux = cnt[CNT_W-1:BUS_W];
            SEL_CTRL:   rd_mux = ctrl_word;
            SEL_STAT:   rd_mux = {{(BUS_W-1){1'b0}}, flag};
            SEL_CMP_LO: rd_mux = cmp[BUS_W-1:0];
            SEL_CMP_HI: rd_mux = cmp[CNT_W-1:BUS_W];
            SEL_STEP:   rd_mux = step;
            default:    rd_mux = '0;
        endcase
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gtmr_chk.sv
// Checker for gtmr_top, bound to every instance. Watches the ports and
// the signals passed between the units.
module gtmr_chk #(
    parameter int HALF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                bus_wdata0,
    input logic [HALF_W-1:0]   bus_rdata,
    input logic                irq_o,
    input logic                run,
    input logic                tick,
    input logic [2*HALF_W-1:0] cnt,
    input logic [2*HALF_W-1:0] cmp,
    input logic [HALF_W-1:0]   step,
    input logic                flag,
    input logic                irq_en,
    input logic                auto_inc,
    input logic                fire
);
    logic cnt_wr;
    logic cmp_wr;
    logic clr_wr;

    // Strobes decoded separately from the design.
    always_comb begin
        cnt_wr = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1);
        cmp_wr = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5);
        clr_wr = bus_wr && (bus_addr == 3'd3) && bus_wdata0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == 1'b0 && bus_rdata == '0 && flag == 1'b0)); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7) |=> (bus_rdata == '0)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt)); // R4
    AST_CNT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1)); // R5
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag); // R7
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && auto_inc && !cmp_wr) |=> (cmp == $past(cmp) + {{HALF_W{1'b0}}, $past(step)})); // R8
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !auto_inc && !cmp_wr) |=> $stable(cmp)); // R9
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(flag && irq_en))); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11

endmodule

bind gtmr_top gtmr_chk #(.HALF_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata0 (bus_wdata[0]),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq_o),
    .run        (run),
    .tick       (tick),
    .cnt        (cnt),
    .cmp        (cmp),
    .step       (step),
    .flag       (flag),
    .irq_en     (irq_en),
    .auto_inc   (auto_inc),
    .fire       (fire)
);

// File: tb/tb_gtmr_top.sv
`timescale 1ns/1ps
module tb_gtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_edge = 0;
    bit done = 1'b0;

    gtmr_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected counter: loaded value plus the ticks at edges E+1 .. last.
    function automatic logic [63:0] exp_count(logic [63:0] init, int p, int e, int last);
        return init + 64'((last - e) / (p + 1));
    endfunction

    function automatic logic [31:0] ctrl_word(int p, bit ai, bit ie, bit ce, bit rn);
        return {16'h0, 8'(p), 4'h0, ai, ie, ce, rn};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write; last_edge = the accepting edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        last_edge = cyc;
    endtask

    // One-cycle read; data sampled at the next falling edge.
    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        last_edge = cyc;
        d = bus_rdata;
    endtask

    task automatic wait_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Load, start, idle, then read both halves against the model.
    task automatic count_run(int p, logic [63:0] init, int idle, string req);
        logic [31:0] v;
        int e;
        wr(3'd2, 32'h0);
        wr(3'd0, init[31:0]);
        wr(3'd1, init[63:32]);
        wr(3'd2, ctrl_word(p, 0, 0, 0, 1));
        e = last_edge;
        repeat (idle) @(negedge clk);
        rd(3'd0, v);
        check(req, {32'h0, v}, {32'h0, exp_count(init, p, e, last_edge - 1)} & 64'hFFFF_FFFF);
        rd(3'd1, v);
        check(req, {32'h0, v}, {32'h0, exp_count(init, p, e, last_edge - 1) >> 32});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        int e;
        int w;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", {63'h0, irq_o}, 64'h0);
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), v);
            check("R1 reg", {32'h0, v}, 64'h0);
        end

        // R2/R11: map, unused bits, unmapped index
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        check("R2 R11 ctrl unused bits", {32'h0, v}, 64'h0000_FF0F);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'hFFFF_FFFE);
        rd(3'd3, v);
        check("R2 status unused bits", {32'h0, v}, 64'h0);
        wr(3'd6, 32'hA5A5_1234);
        rd(3'd6, v);
        check("R2 step", {32'h0, v}, 64'hA5A5_1234);
        wr(3'd4, 32'h1357_9BDF);
        wr(3'd5, 32'h2468_ACE0);
        rd(3'd4, v);
        check("R2 cmp lo", {32'h0, v}, 64'h1357_9BDF);
        rd(3'd5, v);
        check("R2 cmp hi", {32'h0, v}, 64'h2468_ACE0);
        rd(3'd7, v);
        check("R2 unmapped", {32'h0, v}, 64'h0);

        // R5: carry across the word boundary
        count_run(0, 64'h0000_0007_FFFF_FFFE, 3, "R5 carry");
        count_run(2, 64'hFFFF_FFFF_FFFF_FFF0, 60, "R5 carry top");

        // R3: rate and restart under random prescale and start values
        for (int i = 0; i < 24; i++) begin
            logic [63:0] init;
            int p;
            p = int'($urandom % 9);
            init = {$urandom, $urandom};
            if (i % 3 == 0) init[31:0] = 32'hFFFF_FFFF - ($urandom % 8);
            count_run(p, init, int'($urandom % 40), "R3 R5 rate");
        end

        // R4: stop holds the count
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h100);
        wr(3'd1, 32'h0);
        wr(3'd2, ctrl_word(1, 0, 0, 0, 1));
        e = last_edge;
        repeat (10) @(negedge clk);
        wr(3'd2, 32'h0);
        w = last_edge;
        rd(3'd0, v);
        check("R4 stop", {32'h0, v}, exp_count(64'h100, 1, e, w));
        repeat (17) @(negedge clk);
        rd(3'd0, v2);
        check("R4 hold", {32'h0, v2}, {32'h0, v});

        // R6/R7/R8/R10: periodic events, prescale 3
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd20);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'd10);
        wr(3'd3, 32'h1);
        wr(3'd2, ctrl_word(3, 1, 1, 1, 1));
        e = last_edge;
        wait_until(e + 81);
        check("R10 irq before flag", {63'h0, irq_o}, 64'h0);
        wait_until(e + 82);
        check("R6 R10 irq rises", {63'h0, irq_o}, 64'h1);
        rd(3'd4, v);
        check("R8 cmp advanced", {32'h0, v}, 64'd30);
        rd(3'd3, v);
        check("R7 flag sticky", {32'h0, v}, 64'h1);
        wr(3'd3, 32'h1);
        w = last_edge;
        check("R10 irq lags clear", {63'h0, irq_o}, 64'h1);
        wait_until(w + 1);
        check("R7 clear", {63'h0, irq_o}, 64'h0);
        wait_until(e + 121);
        check("R8 no early event", {63'h0, irq_o}, 64'h0);
        wait_until(e + 122);
        check("R8 second event", {63'h0, irq_o}, 64'h1);
        rd(3'd4, v);
        check("R8 cmp again", {32'h0, v}, 64'd40);

        // R9: one-shot with interrupt disabled
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd5);
        wr(3'd5, 32'h0);
        wr(3'd3, 32'h1);
        wr(3'd2, ctrl_word(0, 0, 0, 1, 1));
        e = last_edge;
        wait_until(e + 10);
        check("R10 irq gated", {63'h0, irq_o}, 64'h0);
        rd(3'd3, v);
        check("R6 one-shot flag", {32'h0, v}, 64'h1);
        wr(3'd3, 32'h1);
        repeat (20) @(negedge clk);
        rd(3'd3, v);
        check("R9 no refire", {32'h0, v}, 64'h0);
        rd(3'd4, v);
        check("R9 cmp unchanged", {32'h0, v}, 64'd5);
        wr(3'd2, ctrl_word(0, 0, 1, 1, 1));
        repeat (5) @(negedge clk);
        check("R9 still quiet", {63'h0, irq_o}, 64'h0);
        wr(3'd4, 32'h0);
        w = last_edge;
        check("R6 arm edge", {63'h0, irq_o}, 64'h0);
        wait_until(w + 1);
        check("R10 irq one after flag", {63'h0, irq_o}, 64'h0);
        wait_until(w + 2);
        check("R6 rearmed event", {63'h0, irq_o}, 64'h1);

        // R7: an event in the same cycle as a clear keeps the flag
        wr(3'd2, ctrl_word(0, 1, 0, 1, 1));
        wr(3'd6, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd3, 32'h1);
        repeat (2) @(negedge clk);
        rd(3'd3, v);
        check("R7 event beats clear", {32'h0, v}, 64'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule